// File: doc/BRIEF.md
# Fixed-Point Status Flag Update Unit

This unit derives the status side effects of one integer ALU operation. For each operation it receives the source operands, an optional immediate, the ALU result and a set of per-operation enables. From these it updates a small flag register: carry and low-half carry, overflow and low-half overflow, and a sticky summary overflow. When the operation asks for it, the unit also produces a four-bit condition field that classifies the result.

Carry is not taken from an adder carry chain. A carry is reported when any operand in the operand set, read as unsigned, is greater than the result. The same test runs on the low half of the word for the low-half carry. Overflow uses the sign rule on the first two operands, at full width and on the low half. The summary overflow collects every overflow the unit sees, and only reset clears it.

Each operation arrives as a single-cycle `res_valid` strobe. Every strobe is accepted, so there is no back-pressure and no ready signal. The operation takes effect on the clock edge where the strobe is sampled. The outputs show the new state in the cycle after that edge.

Top module: `fx_flag_unit`

## Requirements
- R1: While `rst_n` is low, every flag output, `cr_field` and `cr_we` are 0.
- R2: When `inv_a` is 1, the bitwise complement of `op_a` is used in place of `op_a` in every flag computation.
- R3: `ca` is set to 1 when any member of the operand set is greater than `result`, both read as unsigned. Otherwise it is set to 0. The operand set always holds (possibly inverted) A. It holds `op_b` only when `b_valid` is 1 and `imm` only when `imm_valid` is 1.
- R4: `ca32` uses the same test as R3, applied to the low LOWW bits (bits LOWW-1:0) of every operand and of the result.
- R5: When `done_mask[0]` is 1, `ca` keeps its value. When `done_mask[1]` is 1, `ca32` keeps its value.
- R6: The second operand is `op_b` when `b_valid` is 1 and `imm` otherwise. `ov` is 1 when A and the second operand have equal sign bits and the result's sign bit differs from them. `ov32` applies the same rule with bit LOWW-1 as the sign.
- R7: On an overflow update, `so` becomes `so | ov_new`. The unit never clears `so` outside reset.
- R8: On a record update, `cr_field` becomes {negative, positive, zero, so}. Bit 3 is the result's sign bit. Bit 2 means the result is nonzero with sign 0. Bit 1 means the result is all zeros. Bit 0 is the summary overflow after this operation's update. `cr_we` is 1 for exactly the one cycle that follows that strobe.
- R9: Carry flags change only when `carry_en` is 1. Overflow flags and `so` change only when both `ov_en` and `ov_ok` are 1. `cr_field` changes and `cr_we` is raised only when `rec_en` is 1.
- R10: A cycle with `res_valid` low leaves every flag and `cr_field` unchanged and makes `cr_we` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | Operation strobe, one per ALU result |
| inv_a | input | 1 | Use complement of op_a |
| op_a | input | XLEN | First operand |
| op_b | input | XLEN | Second register operand |
| b_valid | input | 1 | op_b belongs to the operand set |
| imm | input | XLEN | Immediate operand |
| imm_valid | input | 1 | imm belongs to the operand set |
| result | input | XLEN | ALU result |
| carry_en | input | 1 | Operation writes carry flags |
| ov_en | input | 1 | Operation requests overflow flags |
| ov_ok | input | 1 | Overflow request is valid |
| rec_en | input | 1 | Operation records a condition field |
| done_mask | input | 2 | Bit 0 protects ca, bit 1 protects ca32 |
| ca | output | 1 | Carry |
| ca32 | output | 1 | Low-half carry |
| ov | output | 1 | Overflow |
| ov32 | output | 1 | Low-half overflow |
| so | output | 1 | Sticky summary overflow |
| cr_field | output | 4 | Condition field {neg, pos, zero, so} |
| cr_we | output | 1 | Condition field write pulse |

## Verification
The assertions assume that `rst_n` is synchronous and that the enable inputs are meaningful only while `res_valid` is high. They also assume that the unit owns the flags, so nothing else writes them. The stimulus changes inputs only half a period away from the sampling edge. Each strobe lasts exactly one cycle, and a reset comes before any sweep. The sweep uses an 8-bit word with a 4-bit low half, and every result is the true wrapped sum of the operands. This keeps the comparison-based carry equal to the arithmetic carry that the bench computes.

// File: rtl/fx_flag_pkg.sv
package fx_flag_pkg;

  typedef struct packed {
    logic ca;
    logic ca32;
    logic ov;
    logic ov32;
    logic so;
  } flag_reg_t;

  localparam int unsigned NUM_OPS = 3;

endpackage

// File: rtl/fx_carry_eval.sv
module fx_carry_eval #(
  parameter int unsigned W  = 64,
  parameter int unsigned LW = 32,
  parameter int unsigned N  = 3
) (
  input  logic [N-1:0][W-1:0] ops,
  input  logic [N-1:0]        ops_vld,
  input  logic [W-1:0]        res,
  output logic                ca_n,
  output logic                ca32_n
);
  logic [N-1:0] gt_full;
  logic [N-1:0] gt_low;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign gt_full[i] = ops_vld[i] && (ops[i] > res);
    assign gt_low[i]  = ops_vld[i] && (ops[i][LW-1:0] > res[LW-1:0]);
  end

  assign ca_n   = |gt_full;
  assign ca32_n = |gt_low;
endmodule

// File: rtl/fx_ovf_eval.sv
module fx_ovf_eval #(
  parameter int unsigned W  = 64,
  parameter int unsigned LW = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] r,
  output logic         ov_n,
  output logic         ov32_n
);
  always_comb begin
    ov_n   = (x[W-1] == y[W-1]) && (r[W-1] != x[W-1]);
    ov32_n = (x[LW-1] == y[LW-1]) && (r[LW-1] != x[LW-1]);
  end
endmodule

// File: rtl/fx_cond_eval.sv
module fx_cond_eval #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] r,
  input  logic         so_in,
  output logic [3:0]   cond
);
  logic neg, zero, pos;
  always_comb begin
    neg  = r[W-1];
    zero = (r == '0);
    pos  = !neg && !zero;
    cond = {neg, pos, zero, so_in};
  end
endmodule

// File: rtl/fx_flag_unit.sv
module fx_flag_unit #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned LOWW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            res_valid,
  input  logic            inv_a,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic            b_valid,
  input  logic [XLEN-1:0] imm,
  input  logic            imm_valid,
  input  logic [XLEN-1:0] result,
  input  logic            carry_en,
  input  logic            ov_en,
  input  logic            ov_ok,
  input  logic            rec_en,
  input  logic [1:0]      done_mask,
  output logic            ca,
  output logic            ca32,
  output logic            ov,
  output logic            ov32,
  output logic            so,
  output logic [3:0]      cr_field,
  output logic            cr_we
);
  import fx_flag_pkg::*;

  localparam int unsigned NOPS = NUM_OPS;

  logic [NOPS-1:0][XLEN-1:0] ops;
  logic [NOPS-1:0]           ops_vld;
  logic [XLEN-1:0]           a_eff;
  logic [XLEN-1:0]           second;
  logic                      ca_n, ca32_n, ov_n, ov32_n;
  logic                      ov_upd;
  logic                      so_next;
  logic [3:0]                cond_n;
  flag_reg_t                 flags_q;
  logic [3:0]                cr_q;
  logic                      we_q;

  assign a_eff   = inv_a ? ~op_a : op_a;
  assign ops     = {imm, op_b, a_eff};
  assign ops_vld = {imm_valid, b_valid, 1'b1};
  assign second  = b_valid ? op_b : imm;

  fx_carry_eval #(.W(XLEN), .LW(LOWW), .N(NOPS)) u_carry (
    .ops    (ops),
    .ops_vld(ops_vld),
    .res    (result),
    .ca_n   (ca_n),
    .ca32_n (ca32_n)
  );

  fx_ovf_eval #(.W(XLEN), .LW(LOWW)) u_ovf (
    .x     (a_eff),
    .y     (second),
    .r     (result),
    .ov_n  (ov_n),
    .ov32_n(ov32_n)
  );

  assign ov_upd  = res_valid && ov_en && ov_ok;
  assign so_next = ov_upd ? (flags_q.so | ov_n) : flags_q.so;

  fx_cond_eval #(.W(XLEN)) u_cond (
    .r    (result),
    .so_in(so_next),
    .cond (cond_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      cr_q    <= '0;
      we_q    <= 1'b0;
    end else begin
      we_q <= res_valid && rec_en;
      if (res_valid) begin
        if (carry_en) begin
          if (!done_mask[0]) flags_q.ca   <= ca_n;
          if (!done_mask[1]) flags_q.ca32 <= ca32_n;
        end
        if (ov_en && ov_ok) begin
          flags_q.ov   <= ov_n;
          flags_q.ov32 <= ov32_n;
          flags_q.so   <= so_next;
        end
        if (rec_en) cr_q <= cond_n;
      end
    end
  end

  assign ca       = flags_q.ca;
  assign ca32     = flags_q.ca32;
  assign ov       = flags_q.ov;
  assign ov32     = flags_q.ov32;
  assign so       = flags_q.so;
  assign cr_field = cr_q;
  assign cr_we    = we_q;
endmodule

// File: rtl/fx_flag_unit_chk.sv
module fx_flag_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       res_valid,
  input logic       carry_en,
  input logic       ov_en,
  input logic       ov_ok,
  input logic       rec_en,
  input logic [1:0] done_mask,
  input logic       ca,
  input logic       ca32,
  input logic       ov,
  input logic       ov32,
  input logic       so,
  input logic [3:0] cr_field,
  input logic       cr_we
);
  // R7
  so_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    so |=> so);

  // R8
  cr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && rec_en) |=> cr_we);

  // R8
  cr_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> ($onehot(cr_field[3:1]) && (cr_field[0] == so)));

  // R5
  ca_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && carry_en && done_mask[0]) |=> $stable(ca));

  // R5
  ca32_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && carry_en && done_mask[1]) |=> $stable(ca32));

  // R9
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && carry_en) |=> ($stable(ca) && $stable(ca32)));

  // R9
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && ov_en && ov_ok) |=> ($stable(ov) && $stable(ov32) && $stable(so)));

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> (!cr_we && $stable(cr_field)));
endmodule

bind fx_flag_unit fx_flag_unit_chk u_fx_flag_unit_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .res_valid(res_valid),
  .carry_en (carry_en),
  .ov_en    (ov_en),
  .ov_ok    (ov_ok),
  .rec_en   (rec_en),
  .done_mask(done_mask),
  .ca       (ca),
  .ca32     (ca32),
  .ov       (ov),
  .ov32     (ov32),
  .so       (so),
  .cr_field (cr_field),
  .cr_we    (cr_we)
);

// File: tb/test_fx_flag_unit.sv
`timescale 1ns/1ps
module test_fx_flag_unit;
  localparam int W = 8;
  localparam int L = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic res_valid = 1'b0, inv_a = 1'b0, b_valid = 1'b0, imm_valid = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0, imm = '0, result = '0;
  logic carry_en = 1'b0, ov_en = 1'b0, ov_ok = 1'b0, rec_en = 1'b0;
  logic [1:0] done_mask = 2'b00;
  logic ca, ca32, ov, ov32, so, cr_we;
  logic [3:0] cr_field;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  fx_flag_unit #(.XLEN(W), .LOWW(L)) i_fx_flag_unit (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .inv_a(inv_a),
    .op_a(op_a), .op_b(op_b), .b_valid(b_valid), .imm(imm),
    .imm_valid(imm_valid), .result(result), .carry_en(carry_en),
    .ov_en(ov_en), .ov_ok(ov_ok), .rec_en(rec_en), .done_mask(done_mask),
    .ca(ca), .ca32(ca32), .ov(ov), .ov32(ov32), .so(so),
    .cr_field(cr_field), .cr_we(cr_we)
  );

  function automatic logic [9:0] pk(input logic c, c32, o, o32, s,
                                     input logic [3:0] cr, input logic we);
    return {c, c32, o, o32, s, cr, we};
  endfunction

  task automatic check(input string tag, input logic [9:0] exp);
    logic [9:0] act;
    act = {ca, ca32, ov, ov32, so, cr_field, cr_we};
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic inv, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic bv, input logic iv,
                       input logic [W-1:0] im, input logic [W-1:0] r,
                       input logic ce, input logic oe, input logic ook,
                       input logic rc, input logic [1:0] dm);
    res_valid = v; inv_a = inv; op_a = a; op_b = b; b_valid = bv;
    imm_valid = iv; imm = im; result = r; carry_en = ce; ov_en = oe;
    ov_ok = ook; rec_en = rc; done_mask = dm;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic so_m;
    @(negedge clk);
    do_reset();
    check("R1 reset state", pk(0,0,0,0,0,4'h0,0));

    // R3 immediate joins operand set
    apply(1,0,8'h00,8'hFF,0,1,8'hF0,8'h10, 1,0,0,0,2'b00);
    check("R3 immediate counted", pk(1,0,0,0,0,4'h0,0));
    // R3 invalid B ignored; R4 low half likewise
    apply(1,0,8'h01,8'hFF,0,0,8'h00,8'h02, 1,0,0,0,2'b00);
    check("R3 R4 invalid B ignored", pk(0,0,0,0,0,4'h0,0));
    // R5 mask bit 0 protects ca
    apply(1,0,8'hFF,8'h01,1,0,8'h00,8'h00, 1,0,0,0,2'b01);
    check("R5 ca protected", pk(0,1,0,0,0,4'h0,0));
    // R5 mask bit 1 protects ca32
    apply(1,0,8'h01,8'h01,1,0,8'h00,8'h02, 1,0,0,0,2'b10);
    check("R5 ca32 protected", pk(0,1,0,0,0,4'h0,0));
    // R9 carry_en off
    apply(1,0,8'hFF,8'h01,1,0,8'h00,8'h00, 0,0,0,0,2'b00);
    check("R9 carry disabled", pk(0,1,0,0,0,4'h0,0));
    // R9 ov_ok low blocks overflow; R8 record with so=0
    apply(1,0,8'h7F,8'h01,1,0,8'h00,8'h80, 0,1,0,1,2'b00);
    check("R9 R8 ov invalid, record", pk(0,1,0,0,0,4'h8,1));
    // R6 imm as second operand, R7 so set, R8 so in field
    apply(1,0,8'h7F,8'h00,0,1,8'h01,8'h80, 0,1,1,1,2'b00);
    check("R6 R7 R8 overflow via imm", pk(0,1,1,0,1,4'h9,1));
    // R10 idle cycle
    apply(0,0,8'h00,8'h00,1,0,8'h00,8'h00, 1,1,1,1,2'b00);
    check("R10 no strobe holds", pk(0,1,1,0,1,4'h9,0));
    // R7 so sticky when ov clears
    apply(1,0,8'h01,8'h01,1,0,8'h00,8'h02, 0,1,1,1,2'b00);
    check("R7 so sticky", pk(0,1,0,0,1,4'h5,1));
    // R8 zero result
    apply(1,0,8'h00,8'h00,1,0,8'h00,8'h00, 0,0,0,1,2'b00);
    check("R8 zero class", pk(0,1,0,0,1,4'h3,1));
    // R9 record off
    apply(1,0,8'h80,8'h00,1,0,8'h00,8'h80, 0,0,0,0,2'b00);
    check("R9 record disabled", pk(0,1,0,0,1,4'h3,0));
    // R2 inversion: ~0xFE = 0x01
    apply(1,1,8'hFE,8'h01,1,0,8'h00,8'h02, 1,0,0,0,2'b00);
    check("R2 inverted A", pk(0,0,0,0,1,4'h3,0));

    // sweep: R2 R3 R4 R6 R7 R8 against arithmetic sums
    do_reset();
    check("R1 reset before sweep", pk(0,0,0,0,0,4'h0,0));
    so_m = 1'b0;
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b += 5) begin
        logic inv;
        logic [W-1:0] x, r;
        int sum, sx, sb, lx, lb, ls, sr;
        logic e_ca, e_ca32, e_ov, e_ov32;
        logic [3:0] e_cr;
        inv = logic'((a ^ b) & 1);
        x = inv ? ~W'(a) : W'(a);
        sum = int'(x) + b;
        r = W'(sum);
        e_ca = (sum > 255);
        e_ca32 = ((int'(x[3:0]) + (b & 15)) > 15);
        sx = x[7] ? int'(x) - 256 : int'(x);
        sb = (b > 127) ? b - 256 : b;
        e_ov = ((sx + sb) > 127) || ((sx + sb) < -128);
        lx = x[3] ? int'(x[3:0]) - 16 : int'(x[3:0]);
        lb = ((b & 15) > 7) ? (b & 15) - 16 : (b & 15);
        ls = lx + lb;
        e_ov32 = (ls > 7) || (ls < -8);
        so_m = so_m | e_ov;
        sr = r[7] ? int'(r) - 256 : int'(r);
        e_cr = {sr < 0, sr > 0, sr == 0, so_m};
        apply(1,inv,W'(a),W'(b),1,0,8'h00,r, 1,1,1,1,2'b00);
        check("R2 R3 R4 R6 R7 R8 sweep", pk(e_ca,e_ca32,e_ov,e_ov32,so_m,e_cr,1));
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule